// File: doc/BRIEF.md
# Cassette character transfer sequencer

This block runs one tape operation at a time and moves single 8-bit characters between a host-visible data buffer and a tape-side byte stream. The host drives a strobe together with a function code. The first strobe while the block is idle starts an operation. Later strobes continue it: they hand over the next write character, fetch the last read character, or switch the running block into its CRC phase. An internal pacer produces the character clock. Its first tick comes a fixed start latency after the operation starts, and later ticks follow at a fixed per-character spacing.

Reads and writes are handled differently. A write takes its first character with the start strobe, and a CRC strobe ends the block by emitting the accumulated CRC. A read hands back zero on the start strobe. It then delivers the record bytes followed by two computed CRC bytes. The host can switch to CRC mode to collect the second CRC byte and close the block. Space, rewind and gap-write motion is outside the block: it shows up only as a start pulse and a done input. The block also keeps track of file gaps, so that a gap is skipped when motion starts forward at beginning of tape and is not reported a second time after a direction reversal.

Top module: `cas_xfer_seq`

## Requirements
- R1: Function codes on `func_i` are 0 read, 1 rewind, 2 write, 3 space reverse to gap, 4 write gap, 5 space reverse one block, 6 CRC, 7 space forward to gap. An accepted start while idle clears all four error bits and pulses `op_start_o`. A write start loads `host_data_i` into the data buffer. A read start drives 0 on `host_data_o`.
- R2: Every strobe clears the data flag, unless a character tick sets it on the same edge.
- R3: The first character tick of a read or write comes START_CYC cycles after the start edge, and later ticks come every CHAR_CYC cycles. On a read tick the next record byte enters the buffer and `rd_pop_o` pulses. On a write tick the buffered character appears on `wr_data_o` with a `wr_stb_o` pulse. Both kinds of tick set the data flag.
- R4: A data tick that finds the data flag still set raises `tim_err_o`.
- R5: The CRC is 16 bits and is cleared at start. For each byte, the byte is XORed into bits 15:8, followed by eight right shifts, each XORing 0xA001 when the bit shifted out was 1. A read that reaches `rd_end_i` delivers CRC bits 15:8 and then bits 7:0 as the next two characters. One tick after that it loads 0, sets `crc_err_o` and ends.
- R6: During a read, a read or CRC strobe drives the buffer on `host_data_o`. During a write, a write strobe loads `host_data_i` into the buffer.
- R7: A CRC strobe during a write makes the next tick pulse `blk_end_o` with the CRC of the written characters on `crc_o`. The operation then ends with the data flag clear.
- R8: A CRC strobe during a read returns the buffer. The next tick loads the next character and sets the data flag without a timing error, and the operation ends on the tick after that.
- R9: If CRC mode ends a read before all data bytes of the record were taken, `crc_err_o` is set unless the CRC over the bytes taken is zero.
- R10: `gap_i` seen on a read tick before the record end sets `eof_err_o` and ends the operation.
- R11: A read or space start pulses `skip_gap_o` if it is forward with `at_bot_i` high, or if the previous operation ended in a gap and ran in the opposite direction.
- R12: A write or write-gap start while `wr_lock_i` is high sets `wle_o` and starts nothing.
- R13: Space, rewind and write-gap operations stay busy until `op_done_i`. A space that completes with `gap_i` high sets `eof_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Host start/continue strobe |
| func_i | input | 3 | Function code |
| host_data_i | input | 8 | Character from host |
| host_data_o | output | 8 | Value handed back to host on a strobe |
| db_o | output | 8 | Data buffer |
| df_o | output | 1 | Data flag |
| busy_o | output | 1 | Operation in progress |
| rd_byte_i | input | 8 | Current record byte from tape |
| rd_end_i | input | 1 | Record has no more data bytes |
| gap_i | input | 1 | Tape is at a file gap |
| at_bot_i | input | 1 | Tape is at beginning |
| wr_lock_i | input | 1 | Selected drive is write-locked |
| op_done_i | input | 1 | Motion operation finished |
| rd_pop_o | output | 1 | Record byte consumed |
| wr_stb_o | output | 1 | Write character to tape |
| wr_data_o | output | 8 | Character written to tape |
| blk_end_o | output | 1 | Block closed with CRC |
| crc_o | output | 16 | CRC written at block end |
| op_start_o | output | 1 | Operation accepted |
| skip_gap_o | output | 1 | Skip one file gap before motion |
| tim_err_o | output | 1 | Timing error |
| crc_err_o | output | 1 | CRC or overrun error |
| eof_err_o | output | 1 | End of file reached |
| wle_o | output | 1 | Write to a locked drive |

## Verification
A wrong read tail index shows up at the next tick as a misplaced CRC byte or an early or missing overrun. A wrong CRC accumulator shows up at the two trailing characters or at `crc_o` when the block closes. A mis-set gap or direction memory becomes visible only at the next start, through `skip_gap_o`. For that reason the bench checks that pulse on the edge right after each strobe, across sequences of gap-ending, reversing and beginning-of-tape starts. Pacer faults appear as a wrong count of cycles from the start strobe to the first data flag, or between data flags, and the bench counts both directly.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int unsigned CAS_DW = 8;
  localparam int unsigned CAS_CW = 16;
  localparam logic [CAS_CW-1:0] CAS_POLY = 16'hA001;

  // codes are decoded by the host-side register logic
  typedef enum logic [2:0] {
    FN_READ      = 3'd0,
    FN_REWIND    = 3'd1,
    FN_WRITE     = 3'd2,
    FN_SPC_RFILE = 3'd3,
    FN_GAP_WR    = 3'd4,
    FN_SPC_RBLK  = 3'd5,
    FN_CRC       = 3'd6,
    FN_SPC_FFILE = 3'd7
  } cas_fn_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_RD_CRC, ST_RD_FIN, ST_WR, ST_WR_CRC, ST_MOVE
  } cas_st_e;

  function automatic logic [CAS_CW-1:0] crc_step(input logic [CAS_CW-1:0] c,
                                                 input logic [CAS_DW-1:0] b);
    logic [CAS_CW-1:0] r;
    r = c ^ {b, {(CAS_CW-CAS_DW){1'b0}}};
    for (int i = 0; i < CAS_DW; i++) r = r[0] ? ((r >> 1) ^ CAS_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/cas_pacer.sv
module cas_pacer #(
  parameter int unsigned START_CYC = 1000,
  parameter int unsigned CHAR_CYC  = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned MAXC = (START_CYC > CHAR_CYC) ? START_CYC : CHAR_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= CW'(START_CYC - 1);
    else if (run_i && cnt_q == 0) cnt_q <= CW'(CHAR_CYC - 1);
    else if (run_i)               cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && !load_i && (cnt_q == '0);

  p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && CHAR_CYC > 1) |=> !tick_o);
endmodule

// File: rtl/cas_crc16.sv
module cas_crc16 import cas_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [CAS_DW-1:0] byte_i,
  output logic [CAS_CW-1:0] crc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_o <= '0;
    else if (clr_i) crc_o <= '0;
    else if (en_i)  crc_o <= crc_step(crc_o, byte_i);
  end
endmodule

// File: rtl/cas_xfer_seq.sv
module cas_xfer_seq import cas_pkg::*; #(
  parameter int unsigned START_CYC = 1000,
  parameter int unsigned CHAR_CYC  = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [2:0]        func_i,
  input  logic [CAS_DW-1:0] host_data_i,
  output logic [CAS_DW-1:0] host_data_o,
  output logic [CAS_DW-1:0] db_o,
  output logic              df_o,
  output logic              busy_o,
  input  logic [CAS_DW-1:0] rd_byte_i,
  input  logic              rd_end_i,
  input  logic              gap_i,
  input  logic              at_bot_i,
  input  logic              wr_lock_i,
  input  logic              op_done_i,
  output logic              rd_pop_o,
  output logic              wr_stb_o,
  output logic [CAS_DW-1:0] wr_data_o,
  output logic              blk_end_o,
  output logic [CAS_CW-1:0] crc_o,
  output logic              op_start_o,
  output logic              skip_gap_o,
  output logic              tim_err_o,
  output logic              crc_err_o,
  output logic              eof_err_o,
  output logic              wle_o
);
  cas_st_e           st_q;
  cas_fn_e           fn, move_fn_q;
  logic [CAS_DW-1:0] db_q, host_q, wrd_q;
  logic [CAS_CW-1:0] acc, crc_q;
  logic [1:0]        tail_q;
  logic df_q, tim_q, crce_q, eof_q, wle_q, gap_q, rev_q;
  logic pop_q, wstb_q, bend_q, ostart_q, skip_q;

  assign fn = cas_fn_e'(func_i);

  logic busy, is_wr_fn, is_rev_fn, is_fwd_fn, locked, start_ok, timed_start, run, tick;
  assign busy        = (st_q != ST_IDLE);
  assign is_wr_fn    = (fn == FN_WRITE) || (fn == FN_GAP_WR);
  assign is_rev_fn   = (fn == FN_SPC_RFILE) || (fn == FN_SPC_RBLK);
  assign is_fwd_fn   = (fn == FN_READ) || is_wr_fn || (fn == FN_SPC_FFILE);
  assign locked      = is_wr_fn && wr_lock_i;
  assign start_ok    = go_i && !busy && (fn != FN_CRC) && !locked;
  assign timed_start = start_ok && ((fn == FN_READ) || (fn == FN_WRITE));
  assign run         = busy && (st_q != ST_MOVE);

  cas_pacer #(.START_CYC(START_CYC), .CHAR_CYC(CHAR_CYC)) u_pacer (
    .clk_i, .rst_ni, .load_i(timed_start), .run_i(run), .tick_o(tick)
  );

  // next read character: record data, then CRC high, CRC low, then overrun
  logic [CAS_DW-1:0] nxt_byte;
  logic              take, ovr, rd_gap;
  logic [1:0]        nxt_tail;
  always_comb begin
    nxt_byte = '0;
    take     = 1'b0;
    ovr      = 1'b0;
    nxt_tail = tail_q;
    case (tail_q)
      2'd0: if (!rd_end_i) begin nxt_byte = rd_byte_i; take = 1'b1; end
            else begin nxt_byte = acc[CAS_CW-1:CAS_DW]; nxt_tail = 2'd1; end
      2'd1: begin nxt_byte = acc[CAS_DW-1:0]; nxt_tail = 2'd2; end
      default: ovr = 1'b1;
    endcase
  end
  assign rd_gap = gap_i && (tail_q == 2'd0);

  logic              crc_en, crc_clr;
  logic [CAS_DW-1:0] crc_byte;
  assign crc_clr  = timed_start;
  assign crc_en   = tick && ((st_q == ST_WR) ||
                    (take && ((st_q == ST_RD_CRC) || (st_q == ST_RD && !rd_gap))));
  assign crc_byte = (st_q == ST_WR) ? db_q : rd_byte_i;

  cas_crc16 u_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .en_i(crc_en), .byte_i(crc_byte), .crc_o(acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; move_fn_q <= FN_READ;
      db_q <= '0; host_q <= '0; wrd_q <= '0; crc_q <= '0; tail_q <= '0;
      df_q <= 1'b0; tim_q <= 1'b0; crce_q <= 1'b0; eof_q <= 1'b0; wle_q <= 1'b0;
      gap_q <= 1'b0; rev_q <= 1'b0;
      pop_q <= 1'b0; wstb_q <= 1'b0; bend_q <= 1'b0; ostart_q <= 1'b0; skip_q <= 1'b0;
    end else begin
      pop_q <= 1'b0; wstb_q <= 1'b0; bend_q <= 1'b0; ostart_q <= 1'b0; skip_q <= 1'b0;
      if (go_i) df_q <= 1'b0;
      // host strobe
      if (go_i && !busy) begin
        host_q <= host_data_i;
        if (locked) begin
          wle_q <= 1'b1; tim_q <= 1'b0; crce_q <= 1'b0; eof_q <= 1'b0;
        end else if (start_ok) begin
          wle_q <= 1'b0; tim_q <= 1'b0; crce_q <= 1'b0; eof_q <= 1'b0;
          ostart_q <= 1'b1;
          tail_q   <= '0;
          move_fn_q <= fn;
          if (is_wr_fn || fn == FN_REWIND) begin
            rev_q <= 1'b0; gap_q <= 1'b0;
          end else begin
            rev_q  <= is_rev_fn;
            gap_q  <= 1'b0;
            skip_q <= (is_fwd_fn && at_bot_i) || (gap_q && (is_rev_fn != rev_q));
          end
          case (fn)
            FN_READ:  begin st_q <= ST_RD; db_q <= '0; host_q <= '0; end
            FN_WRITE: begin st_q <= ST_WR; db_q <= host_data_i; end
            default:  st_q <= ST_MOVE;
          endcase
        end else begin
          host_q <= '0;  // CRC code while idle hands back zero
        end
      end else if (go_i) begin
        host_q <= host_data_i;
        case (st_q)
          ST_RD: begin
            if (fn == FN_READ || fn == FN_CRC) host_q <= db_q;
            if (fn == FN_CRC) st_q <= ST_RD_CRC;
          end
          ST_RD_CRC, ST_RD_FIN: if (fn == FN_READ || fn == FN_CRC) host_q <= db_q;
          ST_WR: begin
            if (fn == FN_WRITE) db_q <= host_data_i;
            if (fn == FN_CRC)   st_q <= ST_WR_CRC;
          end
          default: ;
        endcase
      end
      // character tick
      if (tick) begin
        case (st_q)
          ST_RD: begin
            if (rd_gap) begin
              eof_q <= 1'b1; gap_q <= 1'b1; st_q <= ST_IDLE;
            end else if (ovr) begin
              db_q <= '0; crce_q <= 1'b1; st_q <= ST_IDLE;
            end else begin
              db_q <= nxt_byte; tail_q <= nxt_tail; pop_q <= take; df_q <= 1'b1;
              if (df_q && !go_i) tim_q <= 1'b1;
            end
          end
          ST_RD_CRC: begin
            if (ovr) begin db_q <= '0; crce_q <= 1'b1; end
            else begin db_q <= nxt_byte; tail_q <= nxt_tail; pop_q <= take; end
            df_q <= 1'b1;
            st_q <= ST_RD_FIN;
          end
          ST_RD_FIN: begin
            if (tail_q == 2'd0 && acc != '0) crce_q <= 1'b1;
            st_q <= ST_IDLE;
          end
          ST_WR: begin
            wstb_q <= 1'b1; wrd_q <= db_q; df_q <= 1'b1;
            if (df_q && !go_i) tim_q <= 1'b1;
          end
          ST_WR_CRC: begin
            bend_q <= 1'b1; crc_q <= acc; st_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
      // motion handled outside
      if (st_q == ST_MOVE && op_done_i) begin
        st_q <= ST_IDLE;
        if (gap_i && move_fn_q != FN_REWIND && move_fn_q != FN_GAP_WR) begin
          eof_q <= 1'b1; gap_q <= 1'b1;
        end
      end
    end
  end

  assign host_data_o = host_q;
  assign db_o        = db_q;
  assign df_o        = df_q;
  assign busy_o      = busy;
  assign rd_pop_o    = pop_q;
  assign wr_stb_o    = wstb_q;
  assign wr_data_o   = wrd_q;
  assign blk_end_o   = bend_q;
  assign crc_o       = crc_q;
  assign op_start_o  = ostart_q;
  assign skip_gap_o  = skip_q;
  assign tim_err_o   = tim_q;
  assign crc_err_o   = crce_q;
  assign eof_err_o   = eof_q;
  assign wle_o       = wle_q;

  p_strobe_clears_df_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !tick) |=> !df_o);
  p_tim_needs_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tim_err_o) |-> $past(df_o));
  p_lock_blocks_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && !busy_o && func_i == FN_WRITE && wr_lock_i) |=> (wle_o && !busy_o && !op_start_o));
  p_wstb_sets_df_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> df_o);
  p_pulses_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_pop_o, wr_stb_o, blk_end_o}));
  p_blk_end_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_o |-> (!busy_o && !df_o));
endmodule

// File: tb/tb_cas_xfer_seq.sv
module tb_cas_xfer_seq;
  localparam int unsigned S = 20;
  localparam int unsigned C = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic go = 1'b0, rd_end, gap = 1'b0, bot = 1'b0, lock = 1'b0, done = 1'b0;
  logic [2:0] func = 3'd0;
  logic [7:0] hin = 8'd0, hout, db, rbyte, wdat;
  logic df, busy, pop, wstb, bend, ostart, skip, tim, crce, eof, wle;
  logic [15:0] crc;

  cas_xfer_seq #(.START_CYC(S), .CHAR_CYC(C)) dut (
    .clk_i(clk), .rst_ni(rst_n), .go_i(go), .func_i(func), .host_data_i(hin),
    .host_data_o(hout), .db_o(db), .df_o(df), .busy_o(busy), .rd_byte_i(rbyte),
    .rd_end_i(rd_end), .gap_i(gap), .at_bot_i(bot), .wr_lock_i(lock), .op_done_i(done),
    .rd_pop_o(pop), .wr_stb_o(wstb), .wr_data_o(wdat), .blk_end_o(bend), .crc_o(crc),
    .op_start_o(ostart), .skip_gap_o(skip), .tim_err_o(tim), .crc_err_o(crce),
    .eof_err_o(eof), .wle_o(wle)
  );

  // tape model and monitors
  logic [7:0] rec [16];
  int rec_len = 0, rd_base = 0, pop_cnt = 0, wr_n = 0, blk_n = 0;
  logic [7:0] wr_log [64];
  logic [15:0] blk_crc = '0;
  always @(posedge clk) begin
    if (pop) pop_cnt <= pop_cnt + 1;
    if (wstb) begin wr_log[wr_n % 64] <= wdat; wr_n <= wr_n + 1; end
    if (bend) begin blk_crc <= crc; blk_n <= blk_n + 1; end
  end
  assign rbyte  = rec[(pop_cnt - rd_base) % 16];
  assign rd_end = (pop_cnt - rd_base) >= rec_len;

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] b [16], input int n);
    logic [15:0] c = 16'h0;
    for (int i = 0; i < n; i++) begin
      c = c ^ {b[i], 8'h00};
      for (int k = 0; k < 8; k++) begin
        logic lsb = c[0];
        c = {1'b0, c[15:1]};
        if (lsb) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  task automatic strobe(input logic [2:0] f, input logic [7:0] d);
    func = f; hin = d; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic wait_df(input string req, output int n);
    n = 0;
    while (!df && n < 2000) begin @(negedge clk); n++; end
    if (!df) chk({req, " data flag timeout"}, 0, 1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin @(negedge clk); n++; end
    if (busy) chk("idle timeout", 1, 0);
  endtask

  task automatic pulse_done(input logic g);
    gap = g; done = 1'b1;
    @(negedge clk);
    done = 1'b0; gap = 1'b0;
  endtask

  task automatic new_rec(input int len);
    for (int i = 0; i < 16; i++) rec[i] = 8'($urandom_range(255, 0));
    rec_len = len;
    rd_base = pop_cnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("watchdog", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, w0, b0;
    logic [7:0] wb [16];
    logic [15:0] rc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset df", df, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset errors", {tim, crce, eof, wle}, 0);
    chk("R1 reset buffer", db, 0);

    // random write blocks: R1 R2 R3 R6 R7
    for (int t = 0; t < 4; t++) begin
      int len = 1 + int'($urandom_range(5, 0));
      for (int i = 0; i < 16; i++) wb[i] = 8'($urandom_range(255, 0));
      w0 = wr_n; b0 = blk_n;
      strobe(3'd2, wb[0]);
      chk("R1 write start buffer", db, wb[0]);
      chk("R1 write start pulse", ostart, 1);
      wait_df("R3", n);
      chk("R3 start latency", n, S);
      for (int i = 1; i < len; i++) begin
        strobe(3'd2, wb[i]);
        chk("R2 flag cleared", df, 0);
        chk("R6 write buffer", db, wb[i]);
        wait_df("R3", n);
        chk("R3 char spacing", n + 1, C);
      end
      strobe(3'd6, 8'h00);
      wait_idle();
      @(negedge clk);
      chk("R3 write count", wr_n - w0, len);
      for (int i = 0; i < len; i++) chk("R3 write data", wr_log[(w0 + i) % 64], wb[i]);
      chk("R7 block end", blk_n - b0, 1);
      chk("R7 crc value", blk_crc, ref_crc(wb, len));
      chk("R7 no data flag", df, 0);
      chk("R4 no timing error", tim, 0);
    end

    // random full reads: R1 R5 R6 R8
    for (int t = 0; t < 4; t++) begin
      int len = 1 + int'($urandom_range(6, 0));
      new_rec(len);
      rc = ref_crc(rec, len);
      strobe(3'd0, 8'h5A);
      chk("R1 read start returns zero", hout, 0);
      for (int i = 0; i < len; i++) begin
        wait_df("R3", n);
        chk("R3 read buffer", db, rec[i]);
        strobe(3'd0, 8'h00);
        chk("R6 read returns buffer", hout, rec[i]);
        chk("R2 flag cleared", df, 0);
      end
      wait_df("R5", n);
      strobe(3'd6, 8'h00);
      chk("R5 crc high byte", hout, rc[15:8]);
      wait_df("R8", n);
      chk("R8 busy until last tick", busy, 1);
      strobe(3'd6, 8'h00);
      chk("R5 crc low byte", hout, rc[7:0]);
      wait_idle();
      chk("R9 full read no crc error", crce, 0);
      chk("R4 serviced read no timing error", tim, 0);
    end

    // overrun past the CRC bytes: R5
    new_rec(2);
    rc = ref_crc(rec, 2);
    strobe(3'd0, 8'h00);
    for (int i = 0; i < 4; i++) begin
      wait_df("R5", n);
      strobe(3'd0, 8'h00);
      if (i == 2) chk("R5 overrun path crc high", hout, rc[15:8]);
      if (i == 3) chk("R5 overrun path crc low", hout, rc[7:0]);
    end
    wait_idle();
    chk("R5 overrun crc error", crce, 1);
    chk("R5 overrun loads zero", db, 0);

    // unserviced read: R4
    new_rec(4);
    strobe(3'd0, 8'h00);
    wait_df("R4", n);
    repeat (C + 2) @(negedge clk);
    chk("R4 timing error", tim, 1);
    wait_idle();

    // early CRC mode: R8 R9
    new_rec(5);
    strobe(3'd0, 8'h00);
    wait_df("R9", n);
    strobe(3'd0, 8'h00);
    wait_df("R9", n);
    strobe(3'd6, 8'h00);
    chk("R8 crc strobe returns buffer", hout, rec[1]);
    wait_df("R8", n);
    chk("R8 next byte loaded", db, rec[2]);
    chk("R8 busy after second byte", busy, 1);
    chk("R8 no timing error", tim, 0);
    wait_idle();
    chk("R9 partial crc check", crce, (ref_crc(rec, 3) != 16'h0) ? 1 : 0);

    // gaps and skips: R10 R11 R13
    new_rec(3);
    gap = 1'b1;
    strobe(3'd0, 8'h00);
    chk("R11 no skip mid tape", skip, 0);
    wait_idle();
    gap = 1'b0;
    chk("R10 read into gap", eof, 1);
    strobe(3'd5, 8'h00);
    chk("R11 reversal after gap", skip, 1);
    chk("R13 motion start pulse", ostart, 1);
    repeat (3) @(negedge clk);
    chk("R13 busy until done", busy, 1);
    pulse_done(1'b0);
    chk("R13 idle after done", busy, 0);
    chk("R13 no gap no eof", eof, 0);
    strobe(3'd5, 8'h00);
    chk("R11 no skip same state", skip, 0);
    pulse_done(1'b1);
    chk("R13 space into gap", eof, 1);
    new_rec(1);
    strobe(3'd0, 8'h00);
    chk("R11 forward after reverse gap", skip, 1);
    wait_idle();
    bot = 1'b1;
    new_rec(1);
    strobe(3'd0, 8'h00);
    chk("R11 forward at beginning", skip, 1);
    bot = 1'b0;
    wait_idle();
    new_rec(1);
    strobe(3'd0, 8'h00);
    chk("R11 plain forward no skip", skip, 0);
    wait_idle();
    strobe(3'd7, 8'h00);
    pulse_done(1'b1);
    new_rec(1);
    strobe(3'd0, 8'h00);
    chk("R11 same direction after gap", skip, 0);
    wait_idle();

    // write lock: R12
    lock = 1'b1;
    strobe(3'd2, 8'h33);
    chk("R12 lock error", wle, 1);
    chk("R12 no motion", busy, 0);
    chk("R12 no start pulse", ostart, 0);
    strobe(3'd4, 8'h00);
    chk("R12 gap write locked", {wle, busy}, 2'b10);
    lock = 1'b0;
    strobe(3'd4, 8'h00);
    chk("R1 start clears lock error", wle, 0);
    chk("R13 gap write busy", busy, 1);
    pulse_done(1'b1);
    chk("R13 gap write no eof", eof, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule